// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer for a system-on-chip. An 8-bit up-counter advances on ticks from a selectable clock prescaler while the timer is enabled in watchdog mode. When the counter wraps from its maximum value to zero, a sticky overflow flag is set. If reset generation is armed, a system reset pulse of fixed length is also driven. Software keeps the system alive by reloading the counter before it wraps.

Software reaches the block through a simple halfword register bus with an address, a write strobe, a read strobe, write data and combinational read data. Every write must carry the key byte for its register in bits 15:8, or the write is dropped without a trace. The overflow flag can only be cleared with one exact halfword. That clear is honoured only after software has read the reset control register while the flag was set, so a runaway write cannot erase the record of a timeout.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, every register reads as 0x0000, the counter is stopped and the reset output is low.
- R2: The control register is at offset 0. A write there with key 0xA5 in bits 15:8 stores bit 6 (watchdog mode), bit 5 (run enable) and bits 2:0 (divider select). It reads back in the low byte with those bits in the same positions and zeros elsewhere.
- R3: A write whose bits 15:8 do not match the key of the addressed register changes no state.
- R4: The counter is at offset 2. A write there with key 0x5A loads the low byte into the counter and restarts the prescaler. A read returns the live count.
- R5: The counter advances only while both watchdog mode and run enable are set. Writing the control register with run enable clear holds the count.
- R6: Divider selects 0 to 7 give one count every 1, 4, 16, 32, 64, 256, 1024 and 16384 clocks. The k-th count lands exactly k times the ratio clock edges after the last accepted control or counter write.
- R7: When the counter wraps from 255 to 0, bit 7 of the reset control register (offset 4) is set and stays set. The counter continues from 0.
- R8: A write to offset 4 with key 0x5A stores bit 6 as the reset enable, which reads back in bit 6.
- R9: An overflow with reset enable set drives the reset output high for exactly 4 clock cycles, starting on the edge of the wrap. An overflow with reset enable clear leaves the output low.
- R10: Writing exactly 0xA500 to offset 4 clears the overflow flag only if offset 4 was read with the read strobe while the flag was set. Otherwise the write has no effect. The clear leaves the reset enable unchanged.
- R11: Bits 15:8 of every read are zero, and an unmapped offset reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler input |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, arms the flag clear when it hits offset 4 |
| bus_wdata | input | 16 | Write halfword: key in bits 15:8, value in bits 7:0 |
| bus_rdata | output | 16 | Read halfword for bus_addr, combinational |
| sys_rst_out | output | 1 | System reset pulse on overflow |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a 14-bit prescaler and a 4-cycle reset pulse. With these values every divider select can be timed to the exact overflow edge, including the slowest ratio of 16384, within the run budget. Short counter loads near 255 keep each overflow a few ticks away. The reset pulse edges, the armed and unarmed flag clear, and the wrong-key cases are all observed through the register reads and the reset pin.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int unsigned BUS_W = 16;

  localparam logic [7:0]  KEY_CTRL  = 8'hA5;
  localparam logic [7:0]  KEY_COUNT = 8'h5A;
  localparam logic [7:0]  KEY_RCTL  = 8'h5A;
  localparam logic [15:0] WORD_FLAG_CLR = 16'hA500;

  localparam int unsigned OFS_CTRL  = 0;
  localparam int unsigned OFS_COUNT = 2;
  localparam int unsigned OFS_RCTL  = 4;

  typedef struct packed {
    logic       wd_mode;
    logic       run_en;
    logic [2:0] div_sel;
  } ctrl_t;

  // log2 of the divide ratio for each divider select
  function automatic int unsigned div_shift(input logic [2:0] sel);
    case (sel)
      3'd0:    return 0;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 8;
      3'd6:    return 10;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              ovf_evt,
  output ctrl_t             ctrl,
  output logic              rste,
  output logic              flag,
  output logic              cnt_ld,
  output logic [CNT_W-1:0]  cnt_ld_val,
  output logic              presc_clr
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_RCTL  = ADDR_W'(OFS_RCTL);

  logic  hit_ctrl, hit_cnt, hit_rctl, hit_clr, rd_rctl;
  logic  ctrl_we, rste_we, flag_we, armed_we;
  ctrl_t ctrl_d;
  logic  rste_d, flag_d, armed_d, armed;

  // key decode
  always_comb begin
    hit_ctrl = wr && (addr == A_CTRL)  && (wdata[15:8] == KEY_CTRL);
    hit_cnt  = wr && (addr == A_COUNT) && (wdata[15:8] == KEY_COUNT);
    hit_rctl = wr && (addr == A_RCTL)  && (wdata[15:8] == KEY_RCTL);
    hit_clr  = wr && (addr == A_RCTL)  && (wdata == WORD_FLAG_CLR);
    rd_rctl  = rd && (addr == A_RCTL);
  end

  // next state
  always_comb begin
    ctrl_we = hit_ctrl;
    ctrl_d  = '{wd_mode: wdata[6], run_en: wdata[5], div_sel: wdata[2:0]};
    rste_we = hit_rctl;
    rste_d  = wdata[6];

    flag_we = 1'b0;
    flag_d  = flag;
    if (ovf_evt) begin
      flag_we = 1'b1;
      flag_d  = 1'b1;
    end else if (hit_clr && armed) begin
      flag_we = 1'b1;
      flag_d  = 1'b0;
    end

    armed_we = 1'b0;
    armed_d  = armed;
    if (ovf_evt || (hit_clr && armed)) begin
      armed_we = 1'b1;
      armed_d  = 1'b0;
    end else if (rd_rctl && flag) begin
      armed_we = 1'b1;
      armed_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      rste  <= 1'b0;
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (ctrl_we)  ctrl  <= ctrl_d;
      if (rste_we)  rste  <= rste_d;
      if (flag_we)  flag  <= flag_d;
      if (armed_we) armed <= armed_d;
    end
  end

  assign cnt_ld     = hit_cnt;
  assign cnt_ld_val = wdata[CNT_W-1:0];
  assign presc_clr  = hit_cnt || hit_ctrl;

  // read mux
  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[7:0] = {1'b0, ctrl.wd_mode, ctrl.run_en, 2'b00, ctrl.div_sel};
      A_COUNT: rdata[7:0] = 8'(cnt);
      A_RCTL:  rdata[7:0] = {flag, rste, 6'b000000};
      default: rdata      = '0;
    endcase
  end
endmodule

// File: rtl/kwd_prescale.sv
module kwd_prescale
  import kwd_pkg::*;
#(
  parameter int unsigned PRE_W = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clr,
  input  logic [2:0] div_sel,
  output logic       tick
);
  localparam int unsigned N_SEL = 8;

  logic [PRE_W-1:0] lim [N_SEL];
  logic [PRE_W-1:0] presc, presc_d;
  logic             presc_we;

  for (genvar g = 0; g < N_SEL; g++) begin : g_lim
    localparam int unsigned SH = div_shift(3'(g));
    assign lim[g] = PRE_W'((64'd1 << SH) - 64'd1);
  end

  assign tick = run && (presc == lim[div_sel]);

  always_comb begin
    presc_we = 1'b1;
    if (!run || clr || tick) presc_d = '0;
    else                     presc_d = presc + 1'b1;
    if (!run && (presc == '0)) presc_we = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        presc <= '0;
    else if (presc_we) presc <= presc_d;
  end
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_evt
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_we;

  assign ovf_evt = tick && !ld && (cnt == '1);

  always_comb begin
    cnt_we = ld || tick;
    cnt_d  = ld ? ld_val : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_we) cnt <= cnt_d;
  end
endmodule

// File: rtl/kwd_rstgen.sv
module kwd_rstgen #(
  parameter int unsigned RST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic rst_out
);
  localparam int unsigned LW = $clog2(RST_LEN + 1);

  logic [LW-1:0] left, left_d;
  logic          left_we;

  always_comb begin
    left_we = fire || (left != '0);
    left_d  = fire ? LW'(RST_LEN) : left - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left    <= '0;
      rst_out <= 1'b0;
    end else if (left_we) begin
      left    <= left_d;
      rst_out <= (left_d != '0);
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned PRE_W       = 14,
  parameter int unsigned RST_LEN     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              sys_rst_out
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  ctrl_t            ctrl;
  logic             rste, flag, cnt_ld, presc_clr, tick, ovf_evt, run;
  logic [CNT_W-1:0] cnt, cnt_ld_val;

  assign run = ctrl.wd_mode && ctrl.run_en;

  kwd_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .rdata(bus_rdata), .cnt(cnt), .ovf_evt(ovf_evt),
    .ctrl(ctrl), .rste(rste), .flag(flag), .cnt_ld(cnt_ld),
    .cnt_ld_val(cnt_ld_val), .presc_clr(presc_clr)
  );

  kwd_prescale #(.PRE_W(PRE_W)) u_presc (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .clr(presc_clr),
    .div_sel(ctrl.div_sel), .tick(tick)
  );

  kwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .ld(cnt_ld),
    .ld_val(cnt_ld_val), .cnt(cnt), .ovf_evt(ovf_evt)
  );

  kwd_rstgen #(.RST_LEN(RST_LEN)) u_rst (
    .clk(clk), .rst_n(rst_sync_n), .fire(ovf_evt && rste), .rst_out(sys_rst_out)
  );
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [15:0]       bus_wdata,
  input logic [15:0]       bus_rdata,
  input logic              sys_rst_out,
  input logic              ovf_evt,
  input logic              rste,
  input logic              flag,
  input logic              run,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt
);
  logic cnt_wr;
  assign cnt_wr = bus_wr && (bus_addr == ADDR_W'(2)) && (bus_wdata[15:8] == 8'h5A);

  assert_cnt_source_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(cnt) |-> ($past(tick) || $past(cnt_wr)));

  assert_halt_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!run && !cnt_wr) |=> $stable(cnt));

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ovf_evt |=> flag);

  assert_pulse_src_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sys_rst_out) |-> $past(ovf_evt && rste));

  assert_pulse_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sys_rst_out) |=> sys_rst_out);

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(flag) |-> $past(bus_wr && (bus_addr == ADDR_W'(4)) && (bus_wdata == 16'hA500)));

  assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rdata[15:8] == 8'h00);
endmodule

bind keyed_wdog keyed_wdog_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst_out(sys_rst_out),
  .ovf_evt(ovf_evt), .rste(rste), .flag(flag), .run(run), .tick(tick), .cnt(cnt)
);

// File: tb/keyed_wdog_tb.sv
`timescale 1ns/1ps
module keyed_wdog_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sys_rst_out;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  keyed_wdog u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst_out(sys_rst_out)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic [7:0]  ld;
    int unsigned cyc;
  } vec_t;

  // cycles = (256 - load) * ratio
  localparam vec_t VEC [9] = '{
    '{3'd0, 8'd255, 1},
    '{3'd0, 8'd200, 56},
    '{3'd1, 8'd250, 24},
    '{3'd2, 8'd254, 32},
    '{3'd3, 8'd252, 128},
    '{3'd4, 8'd240, 1024},
    '{3'd5, 8'd255, 256},
    '{3'd6, 8'd253, 3072},
    '{3'd7, 8'd255, 16384}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    peek(3'd0, v); check("R1 ctrl", v, 16'h0000);
    peek(3'd2, v); check("R1 count", v, 16'h0000);
    peek(3'd4, v); check("R1 rctl", v, 16'h0000);
    check("R1 rst_out", {15'd0, sys_rst_out}, 16'h0000);

    // R2 field placement and masking
    bus_write(3'd0, 16'hA547);
    peek(3'd0, v); check("R2 readback", v, 16'h0047);
    bus_write(3'd0, 16'hA5FF);
    peek(3'd0, v); check("R2 masked bits", v, 16'h0067);
    bus_write(3'd0, 16'hA500);

    // R3 wrong keys
    bus_write(3'd2, 16'h5A33);
    bus_write(3'd0, 16'h1265);
    peek(3'd0, v); check("R3 ctrl wrong key", v, 16'h0000);
    bus_write(3'd2, 16'hA577);
    peek(3'd2, v); check("R3 count wrong key", v, 16'h0033);
    bus_write(3'd4, 16'h1240);
    peek(3'd4, v); check("R3 rctl wrong key", v, 16'h0000);

    // R4 load while stopped, then live count
    bus_write(3'd2, 16'h5A10);
    peek(3'd2, v); check("R4 load", v, 16'h0010);
    bus_write(3'd0, 16'hA560);
    repeat (5) @(negedge clk);
    peek(3'd2, v); check("R4 live count", v, 16'h0015);

    // R5 stop holds; mode clear with enable set does not count
    bus_write(3'd0, 16'hA500);
    peek(3'd2, v);
    begin
      logic [15:0] held;
      held = v;
      repeat (20) @(negedge clk);
      peek(3'd2, v); check("R5 stopped hold", v, held);
      bus_write(3'd0, 16'hA520);
      repeat (20) @(negedge clk);
      peek(3'd2, v); check("R5 no mode no count", v, held);
      bus_write(3'd0, 16'hA500);
    end

    // R6 / R7 table of divider timings, reset disabled
    for (int i = 0; i < 9; i++) begin
      bus_write(3'd0, 16'hA500);
      bus_read(3'd4, v);
      bus_write(3'd4, 16'hA500);
      bus_write(3'd4, 16'h5A00);
      peek(3'd4, v); check("R10 clear after read", v, 16'h0000);
      bus_write(3'd2, {8'h5A, VEC[i].ld});
      bus_write(3'd0, {8'hA5, 5'b01100, VEC[i].sel});
      repeat (VEC[i].cyc - 1) @(negedge clk);
      peek(3'd4, v); check("R6 no early overflow", v, 16'h0000);
      @(negedge clk);
      peek(3'd4, v); check("R6 R7 overflow edge", v, 16'h0080);
      peek(3'd2, v); check("R7 wrap to zero", v, 16'h0000);
      check("R9 no pulse when disabled", {15'd0, sys_rst_out}, 16'h0000);
    end

    // R8 / R9 reset pulse
    bus_write(3'd0, 16'hA500);
    bus_read(3'd4, v);
    bus_write(3'd4, 16'hA500);
    bus_write(3'd4, 16'h5A40);
    peek(3'd4, v); check("R8 rste readback", v, 16'h0040);
    bus_write(3'd2, 16'h5AFE);
    bus_write(3'd0, 16'hA560);
    check("R9 low at start", {15'd0, sys_rst_out}, 16'h0000);
    @(negedge clk);
    check("R9 low before wrap", {15'd0, sys_rst_out}, 16'h0000);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R9 pulse high", {15'd0, sys_rst_out}, 16'h0001);
    end
    @(negedge clk);
    check("R9 pulse ended", {15'd0, sys_rst_out}, 16'h0000);
    bus_write(3'd0, 16'hA500);

    // R10 clear without arming read, then armed
    bus_write(3'd4, 16'hA500);
    peek(3'd4, v); check("R10 unarmed clear ignored", v, 16'h00C0);
    bus_read(3'd4, v);
    bus_write(3'd4, 16'hA500);
    peek(3'd4, v); check("R10 armed clear keeps rste", v, 16'h0040);

    // R11 unmapped offset
    peek(3'd6, v); check("R11 unmapped", v, 16'h0000);
    peek(3'd1, v); check("R11 unmapped odd", v, 16'h0000);

    finish_run();
  end
endmodule